// File: doc/BRIEF.md
# Video RAM Fetch Timing Sequencer

This block sequences the character-cell timing of a text-and-graphics display controller that runs from a single master oscillator. It uses one phase counter on that clock to derive every timing event. These are the dot-rate enable, the character clock enable that steps the external display-address generator, the graphics shift-register load strobe, and the multiplexed RAS/CAS strobes for the video DRAM. Every derived timing signal is a one-cycle enable or a registered level on the oscillator clock. No clock is gated.

Once in each character cell, the block captures the display refresh address. It drives the row half and then the column half of that address onto the DRAM address pins. It then captures the two bytes the DRAM returns, each with its own strobe. The first byte becomes the character-generator address and the second becomes the attribute byte. A two-bit mode input selects one of four modes: narrow text, wide text, medium-resolution graphics and high-resolution graphics. The mode sets the dot rate and the load-strobe rate, and the whole fetch sequence is re-phased to match.

Top module: `vid_fetch_seq`

## Requirements
- R1: A synchronous active-high reset clears the phase counter, the captured address, the character code and the attribute. After reset is released, ras_n and cas_n stay high for the whole first character cell.
- R2: `mode` is encoded as 0 = narrow text, 1 = wide text, 2 = medium graphics, 3 = high graphics, and bit 0 selects the wide timing. With bit 0 high, dot_en is high on every oscillator cycle. With bit 0 low, dot_en is high on every second cycle, first on the second cycle after reset.
- R3: A character cell lasts DOTS dot slots, numbered 0 to DOTS-1. char_en pulses on the dot enable of slot 0, and on no other cycle.
- R4: crtc_addr is captured on the dot enable of slot 1. vram_addr then carries the low AW/2 bits of the captured address during slots 2 to DOTS/2-1, and the high AW/2 bits during slots DOTS/2 to DOTS-1.
- R5: After the first cell, ras_n is low during slots 2 to DOTS-1 and cas_n is low during slots DOTS/2+1 to DOTS-1. Both are high in all other slots, so CAS is never low while RAS is high.
- R6: vram_ras_n is low only when ras_n is low and vram_sel is high.
- R7: vram_data is stored into cg_code on the dot enable of slot DOTS-2 and into attr on the dot enable of slot DOTS-1. Both registers hold their value at all other times, and neither is loaded during the first cell.
- R8: load_en pulses on the dot enable of slot DOTS-1. In mode 2 it pulses in every cell. In mode 3 it pulses only in odd-numbered cells counted from reset (cell 0 is the first), which doubles its period. In the text modes it never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Display mode select |
| crtc_addr | input | AW | Refresh address from the display-address generator |
| vram_sel | input | 1 | Video RAM select decode |
| vram_data | input | DW | Data byte returned by the video DRAM |
| dot_en | output | 1 | Dot-rate enable |
| char_en | output | 1 | Character clock enable for the address generator |
| load_en | output | 1 | Graphics shift-register load strobe |
| ras_n | output | 1 | Internal row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| vram_ras_n | output | 1 | Row strobe to the video RAM, gated by vram_sel |
| vram_addr | output | AW/2 | Multiplexed row/column address |
| cg_code | output | DW | Character-generator address |
| attr | output | DW | Attribute byte |

## Verification
The bench uses the default parameters: eight dots per cell, a 14-bit address and 8-bit data. It runs all four modes in turn, resetting before each one. In each mode it checks every output on every oscillator cycle of forty character cells against an arithmetic model built from the cycle count, so every slot of every cell is covered under both dot rates. Forty cells is enough to show the odd/even pattern of the high-graphics load strobe and the silent first cell after reset. Because the address and data change in every cell and slot, a wrong capture slot or a swapped half shows up as a mismatch in the value.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
    typedef enum logic [1:0] {
        MODE_TXT_NARROW = 2'd0,
        MODE_TXT_WIDE   = 2'd1,
        MODE_GFX_MED    = 2'd2,
        MODE_GFX_HIGH   = 2'd3
    } vmode_e;
endpackage

// File: rtl/vfs_timebase.sv
module vfs_timebase #(
    parameter int DOTS = 8,
    parameter int SW   = $clog2(DOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wide,
    output logic          dot_en,
    output logic [SW-1:0] slot,
    output logic          armed,
    output logic          half
);
    localparam int PW = SW + 1;

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          armed;
        logic          half;
    } tb_s;

    tb_s s_d, s_q;
    logic wrap;

    always_comb begin
        dot_en = wide | s_q.ph[0];
        slot   = wide ? s_q.ph[SW-1:0] : s_q.ph[PW-1:1];
        armed  = s_q.armed;
        half   = s_q.half;
        wrap   = dot_en && (slot == SW'(DOTS - 1));
        s_d    = s_q;
        if (wrap) begin
            s_d.ph    = '0;
            s_d.armed = 1'b1;
            s_d.half  = ~s_q.half;
        end else begin
            s_d.ph = s_q.ph + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dot_en && slot == SW'(DOTS - 1)) |=> (slot == '0)); // R3
endmodule

// File: rtl/vfs_strobes.sv
module vfs_strobes #(
    parameter int DOTS = 8,
    parameter int SW   = $clog2(DOTS)
) (
    input  vfs_pkg::vmode_e mode,
    input  logic          dot_en,
    input  logic [SW-1:0] slot,
    input  logic          armed,
    input  logic          half,
    output logic          char_en,
    output logic          cap_en,
    output logic          col_sel,
    output logic          ras_n,
    output logic          cas_n,
    output logic          code_en,
    output logic          attr_en,
    output logic          load_en
);
    localparam int S_CAP  = 1;
    localparam int S_RAS  = 2;
    localparam int S_COL  = DOTS / 2;
    localparam int S_CAS  = DOTS / 2 + 1;
    localparam int S_CODE = DOTS - 2;
    localparam int S_ATTR = DOTS - 1;

    logic gfx, hi_gfx;

    always_comb begin
        gfx     = (mode == vfs_pkg::MODE_GFX_MED) || (mode == vfs_pkg::MODE_GFX_HIGH);
        hi_gfx  = (mode == vfs_pkg::MODE_GFX_HIGH);
        char_en = dot_en && (slot == '0);
        cap_en  = dot_en && (slot == SW'(S_CAP));
        col_sel = (slot >= SW'(S_COL));
        ras_n   = !(armed && (slot >= SW'(S_RAS)));
        cas_n   = !(armed && (slot >= SW'(S_CAS)));
        code_en = armed && dot_en && (slot == SW'(S_CODE));
        attr_en = armed && dot_en && (slot == SW'(S_ATTR));
        load_en = gfx && dot_en && (slot == SW'(S_ATTR)) && (!hi_gfx || half);
    end
endmodule

// File: rtl/vfs_fetch_latch.sv
module vfs_fetch_latch #(
    parameter int AW = 14,
    parameter int DW = 8,
    parameter int HW = AW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic          code_en,
    input  logic          attr_en,
    input  logic          col_sel,
    input  logic [AW-1:0] crtc_addr,
    input  logic [DW-1:0] vram_data,
    output logic [HW-1:0] vram_addr,
    output logic [DW-1:0] cg_code,
    output logic [DW-1:0] attr
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] code;
        logic [DW-1:0] attr;
    } lat_s;

    lat_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cap_en)  s_d.addr = crtc_addr;
        if (code_en) s_d.code = vram_data;
        if (attr_en) s_d.attr = vram_data;
        vram_addr = col_sel ? s_q.addr[AW-1:AW-HW] : s_q.addr[HW-1:0];
        cg_code   = s_q.code;
        attr      = s_q.attr;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(s_q.addr)); // R4
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !code_en |=> $stable(cg_code)); // R7
    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !attr_en |=> $stable(attr)); // R7
endmodule

// File: rtl/vid_fetch_seq.sv
module vid_fetch_seq #(
    parameter int DOTS = 8,
    parameter int AW   = 14,
    parameter int DW   = 8,
    parameter int HW   = AW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] crtc_addr,
    input  logic          vram_sel,
    input  logic [DW-1:0] vram_data,
    output logic          dot_en,
    output logic          char_en,
    output logic          load_en,
    output logic          ras_n,
    output logic          cas_n,
    output logic          vram_ras_n,
    output logic [HW-1:0] vram_addr,
    output logic [DW-1:0] cg_code,
    output logic [DW-1:0] attr
);
    localparam int SW = $clog2(DOTS);

    vfs_pkg::vmode_e mode_e;
    logic [SW-1:0]   slot;
    logic            armed, half, cap_en, col_sel, code_en, attr_en;

    assign mode_e = vfs_pkg::vmode_e'(mode);

    vfs_timebase #(.DOTS(DOTS), .SW(SW)) u_tb (
        .clk(clk), .rst(rst), .wide(mode[0]),
        .dot_en(dot_en), .slot(slot), .armed(armed), .half(half)
    );

    vfs_strobes #(.DOTS(DOTS), .SW(SW)) u_stb (
        .mode(mode_e), .dot_en(dot_en), .slot(slot), .armed(armed), .half(half),
        .char_en(char_en), .cap_en(cap_en), .col_sel(col_sel),
        .ras_n(ras_n), .cas_n(cas_n), .code_en(code_en), .attr_en(attr_en),
        .load_en(load_en)
    );

    vfs_fetch_latch #(.AW(AW), .DW(DW), .HW(HW)) u_lat (
        .clk(clk), .rst(rst), .cap_en(cap_en), .code_en(code_en),
        .attr_en(attr_en), .col_sel(col_sel), .crtc_addr(crtc_addr),
        .vram_data(vram_data), .vram_addr(vram_addr), .cg_code(cg_code),
        .attr(attr)
    );

    assign vram_ras_n = ras_n | ~vram_sel;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ras_n && cas_n)); // R1
    AST_CAS_IN_RAS: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n); // R5
    AST_CHAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        char_en |=> !char_en); // R3
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !load_en); // R8
endmodule

// File: tb/vid_fetch_seq_bench.sv
module vid_fetch_seq_bench;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [13:0] crtc_addr = '0;
    logic        vram_sel = 1'b0;
    logic [7:0]  vram_data = '0;
    logic        dot_en, char_en, load_en, ras_n, cas_n, vram_ras_n;
    logic [6:0]  vram_addr;
    logic [7:0]  cg_code, attr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vid_fetch_seq u_vid_fetch_seq (
        .clk(clk), .rst(rst), .mode(mode), .crtc_addr(crtc_addr),
        .vram_sel(vram_sel), .vram_data(vram_data), .dot_en(dot_en),
        .char_en(char_en), .load_en(load_en), .ras_n(ras_n), .cas_n(cas_n),
        .vram_ras_n(vram_ras_n), .vram_addr(vram_addr), .cg_code(cg_code),
        .attr(attr)
    );

    function automatic logic [13:0] addr_of(int c);
        return 14'(c * 293 + 11);
    endfunction

    function automatic logic [7:0] data_of(int t);
        return 8'(t * 7 + 3);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s mode=%0d actual=%0h expected=%0h", req, mode, act, exp);
        end
    endtask

    task automatic run_mode(int m);
        int p;
        logic [7:0] e_code, e_attr;
        p = m[0] ? 1 : 2;
        mode = m[1:0];
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ras_n in reset", int'(ras_n), 1);
        chk("R1 cas_n in reset", int'(cas_n), 1);
        chk("R1 cg_code in reset", int'(cg_code), 0);
        chk("R1 attr in reset", int'(attr), 0);
        rst = 1'b0;
        e_code = '0;
        e_attr = '0;
        for (int t = 0; t < p * D * 40; t++) begin
            int sl, c;
            bit de, arm, e_ras;
            if (t != 0) @(negedge clk);
            sl  = (t / p) % D;
            c   = t / (p * D);
            de  = (t % p) == p - 1;
            arm = c >= 1;
            crtc_addr = addr_of(c);
            vram_data = data_of(t);
            vram_sel  = t[2] ^ t[5];
            #1;
            e_ras = !(arm && sl >= 2);
            chk("R2 dot_en", int'(dot_en), int'(de));
            chk("R3 char_en", int'(char_en), int'(de && sl == 0));
            chk(arm ? "R5 ras_n" : "R1 ras_n first cell", int'(ras_n), int'(e_ras));
            chk(arm ? "R5 cas_n" : "R1 cas_n first cell", int'(cas_n), int'(!(arm && sl >= 5)));
            chk("R6 vram_ras_n", int'(vram_ras_n), int'(e_ras || !vram_sel));
            if (sl >= 2 && sl < 4)
                chk("R4 row half", int'(vram_addr), int'(addr_of(c) & 14'h7F));
            if (sl >= 4)
                chk("R4 column half", int'(vram_addr), int'(addr_of(c) >> 7));
            chk("R8 load_en", int'(load_en),
                int'(m[1] && de && sl == D - 1 && (m != 3 || c % 2 == 1)));
            chk("R7 cg_code", int'(cg_code), int'(e_code));
            chk("R7 attr", int'(attr), int'(e_attr));
            @(posedge clk);
            if (arm && de && sl == D - 2) e_code = data_of(t);
            if (arm && de && sl == D - 1) e_attr = data_of(t);
        end
    endtask

    initial begin
        for (int m = 0; m < 4; m++) run_mode(m);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule